// File: doc/BRIEF.md
# Interrupt Routing Core

This block collects level-sensitive interrupt requests from a set of numbered sources and presents them to several targets, called contexts. Each context drives one interrupt output line. Software configures the block through a single-cycle register port: a priority for each source, a per-context set of enable bits, and a per-context threshold. Software can also raise a source directly by setting its pending bit.

Each source has a gateway, which is a three-state machine:
- **GW_IDLE → GW_PEND** (request): the request line is high, or software sets the pending bit.
- **GW_PEND → GW_BUSY** (claim): a context claims the source.
- **GW_BUSY → GW_IDLE** (completion): software writes the source's ID to a completion register.

A context services an interrupt in two steps. First it reads its claim register. The read returns the best waiting source and moves that source to GW_BUSY in the same cycle. When the handler finishes, software writes that ID back to the same register.

Context numbering is fixed. Context `2*k` is processor core `k` at its machine privilege level, and context `2*k+1` is the same core at its supervisor level.

Top module: `intc_core`

## Requirements
- R1: After reset, every source priority, pending bit, enable bit and threshold reads back as 0, every claim read returns 0, and every `ctx_irq_o` bit is low.
- R2: Source `s` has its priority register at byte address `4*s`. The register holds the low `PRIO_W` bits of the written word and reads back with the upper bits zero. Source 0's register always reads 0 and ignores writes.
- R3: A high request line on a source whose gateway is idle makes that source pending at the next clock edge. Pending is visible at byte address `0x1000 + 4*(s/32)`, bit `s%32`.
- R4: A write to a pending word makes every source whose data bit is 1 pending at the next edge, provided its gateway is idle. Data bits of 0 change nothing.
- R5: Context `c` has its enable bit for source `s` at byte address `0x2000 + 0x80*c + 4*(s/32)`, bit `s%32`. Bits are read/write, and the bit for source 0 always reads 0.
- R6: Context `c` has its threshold register at byte address `0x200000 + 0x1000*c`. It holds the low `PRIO_W` bits of the written word.
- R7: `ctx_irq_o[c]` is high exactly when some source is pending, enabled for `c`, and has a priority strictly above `c`'s threshold. A priority of 0 never interrupts. The output follows the register state with no added delay.
- R8: A read of context `c`'s claim register (threshold address + 4) returns the ID of the pending source enabled for `c` that has the highest non-zero priority. Ties go to the lowest ID. The read returns 0 if no such source exists. The threshold does not affect the result.
- R9: A claim read that returns a non-zero ID clears that source's pending bit at the next edge. Until completion, the gateway ignores both its request line and software pending writes.
- R10: Writing an in-flight ID to any claim register returns that gateway to idle. If the request line is still high, the source is pending again one edge later. A completion naming a source that is not in flight changes nothing.
- R11: Reads of addresses outside the mapped registers return 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_irq_i | input | NSRC-1 | Level request lines for sources 1 to NSRC-1 |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 26 | Byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the same cycle as the strobe |
| ctx_irq_o | output | NCTX | One interrupt line per context |

## Verification
The gateway checks assume that a claim only ever reaches a source that is pending. This holds because the claim ID comes from each context's selector, which considers only pending sources. The checks also assume that at most one access occurs per cycle, so a claim and a completion never coincide; the single register strobe guarantees this.

The stimulus keeps addresses word-aligned and usually inside the mapped windows, with a few deliberately unmapped probes. Completion writes carry IDs drawn from the source range, so both in-flight and idle completions occur. Request lines toggle at random while sources are in flight, which exercises the blocking rule of R9.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int ADDR_W = 26;

    localparam logic [ADDR_W-1:0] PEND_BASE = 26'h000_1000;
    localparam logic [ADDR_W-1:0] EN_BASE   = 26'h000_2000;
    localparam logic [ADDR_W-1:0] CTX_BASE  = 26'h020_0000;

    typedef enum logic [1:0] {
        GW_IDLE = 2'd0,
        GW_PEND = 2'd1,
        GW_BUSY = 2'd2
    } gw_state_e;

endpackage

// File: rtl/intc_gateway.sv
module intc_gateway
    import intc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic sw_set_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pending_o,
    output logic busy_o
);

    gw_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GW_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_IDLE: if (line_i || sw_set_i) state_d = GW_PEND;
            GW_PEND: if (claim_i)            state_d = GW_BUSY;
            GW_BUSY: if (complete_i)         state_d = GW_IDLE;
            default:                         state_d = GW_IDLE;
        endcase
    end

    always_comb begin
        pending_o = (state_q == GW_PEND);
        busy_o    = (state_q == GW_BUSY);
    end

    p_claim_when_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        claim_i |-> state_q == GW_PEND);

    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GW_BUSY && !complete_i) |=> state_q == GW_BUSY);

    p_request_pends_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GW_IDLE && line_i) |=> pending_o);

endmodule

// File: rtl/intc_select.sv
module intc_select #(
    parameter int NSRC   = 40,
    parameter int PRIO_W = 3,
    parameter int ID_W   = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]        pend_i,
    input  logic [NSRC-1:0]        en_i,
    input  logic [NSRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]      thr_i,
    output logic [ID_W-1:0]        best_id_o,
    output logic                   irq_o
);

    logic [PRIO_W-1:0] best_p;
    logic [PRIO_W-1:0] cand_p;

    // Scan from the top ID down; ">=" lets a lower ID take a tie.
    always_comb begin
        best_p    = '0;
        best_id_o = '0;
        cand_p    = '0;
        for (int s = NSRC - 1; s >= 1; s--) begin
            cand_p = prio_i[s*PRIO_W +: PRIO_W];
            if (pend_i[s] && en_i[s] && cand_p != '0 && cand_p >= best_p) begin
                best_p    = cand_p;
                best_id_o = ID_W'(s);
            end
        end
        irq_o = (best_p > thr_i);
    end

endmodule

// File: rtl/intc_core.sv
module intc_core
    import intc_pkg::*;
#(
    parameter int NSRC   = 40,
    parameter int NCTX   = 4,
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:1]   src_irq_i,
    input  logic              reg_req_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic [NCTX-1:0]   ctx_irq_o
);

    localparam int ID_W   = $clog2(NSRC);
    localparam int NWORDS = (NSRC + 31) / 32;

    // ---------------- address decode ----------------
    logic rd_en, wr_en;
    logic [ADDR_W-1:2] en_off;
    logic [ADDR_W-1:0] ctx_off;
    int prio_idx, pend_word, en_ctx, en_word, ctx_sel;
    logic hit_prio, hit_pend, hit_en, hit_thr, hit_clm;

    assign rd_en     = reg_req_i & ~reg_we_i;
    assign wr_en     = reg_req_i &  reg_we_i;
    assign en_off    = reg_addr_i[ADDR_W-1:2] - EN_BASE[ADDR_W-1:2];
    assign ctx_off   = reg_addr_i - CTX_BASE;
    assign prio_idx  = int'(reg_addr_i[11:2]);
    assign pend_word = int'(reg_addr_i[11:2]);
    assign en_ctx    = int'(en_off[ADDR_W-1:7]);
    assign en_word   = int'(en_off[6:2]);
    assign ctx_sel   = int'(ctx_off[ADDR_W-1:12]);

    assign hit_prio = (reg_addr_i < PEND_BASE) && (prio_idx < NSRC);
    assign hit_pend = (reg_addr_i >= PEND_BASE) && (reg_addr_i < EN_BASE) && (pend_word < NWORDS);
    assign hit_en   = (reg_addr_i >= EN_BASE) && (reg_addr_i < CTX_BASE)
                      && (en_ctx < NCTX) && (en_word < NWORDS);
    assign hit_thr  = (reg_addr_i >= CTX_BASE) && (ctx_sel < NCTX) && (ctx_off[11:0] == 12'h000);
    assign hit_clm  = (reg_addr_i >= CTX_BASE) && (ctx_sel < NCTX) && (ctx_off[11:0] == 12'h004);

    // ---------------- configuration storage ----------------
    logic [PRIO_W-1:0] prio_q [NSRC];
    logic [NSRC-1:0]   en_q   [NCTX];
    logic [PRIO_W-1:0] thr_q  [NCTX];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NSRC; s++) prio_q[s] <= '0;
            for (int c = 0; c < NCTX; c++) begin
                en_q[c]  <= '0;
                thr_q[c] <= '0;
            end
        end else if (wr_en) begin
            for (int s = 1; s < NSRC; s++)
                if (hit_prio && prio_idx == s) prio_q[s] <= reg_wdata_i[PRIO_W-1:0];
            for (int c = 0; c < NCTX; c++) begin
                for (int s = 1; s < NSRC; s++)
                    if (hit_en && en_ctx == c && en_word == s / 32)
                        en_q[c][s] <= reg_wdata_i[s % 32];
                if (hit_thr && ctx_sel == c) thr_q[c] <= reg_wdata_i[PRIO_W-1:0];
            end
        end
    end

    // ---------------- claim / complete ----------------
    logic [ID_W-1:0] best_id [NCTX];
    logic [ID_W-1:0] clm_id;
    logic [ID_W-1:0] cmp_id;
    logic clm_fire, cmp_fire, cmp_ok;

    assign clm_fire = rd_en & hit_clm;
    assign cmp_fire = wr_en & hit_clm;
    assign cmp_id   = reg_wdata_i[ID_W-1:0];
    assign cmp_ok   = (reg_wdata_i < 32'(NSRC)) && (cmp_id != '0);

    always_comb begin
        clm_id = '0;
        for (int c = 0; c < NCTX; c++)
            if (ctx_sel == c) clm_id = best_id[c];
    end

    // ---------------- gateways ----------------
    logic [NSRC-1:0] pend_vec, busy_vec;
    assign pend_vec[0] = 1'b0;
    assign busy_vec[0] = 1'b0;

    for (genvar s = 1; s < NSRC; s++) begin : g_gw
        logic sw_set, claim, complete;
        assign sw_set   = wr_en & hit_pend & (pend_word == s / 32) & reg_wdata_i[s % 32];
        assign claim    = clm_fire & (clm_id == ID_W'(s));
        assign complete = cmp_fire & (reg_wdata_i == 32'(s));

        intc_gateway u_gw (
            .clk        (clk),
            .rst_n      (rst_n),
            .line_i     (src_irq_i[s]),
            .sw_set_i   (sw_set),
            .claim_i    (claim),
            .complete_i (complete),
            .pending_o  (pend_vec[s]),
            .busy_o     (busy_vec[s])
        );
    end

    // ---------------- per-context selection ----------------
    logic [NSRC*PRIO_W-1:0] prio_flat;
    for (genvar s = 0; s < NSRC; s++) begin : g_flat
        assign prio_flat[s*PRIO_W +: PRIO_W] = prio_q[s];
    end

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        intc_select #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_sel (
            .pend_i    (pend_vec),
            .en_i      (en_q[c]),
            .prio_i    (prio_flat),
            .thr_i     (thr_q[c]),
            .best_id_o (best_id[c]),
            .irq_o     (ctx_irq_o[c])
        );
    end

    // ---------------- read mux ----------------
    always_comb begin
        reg_rdata_o = '0;
        if (rd_en) begin
            if (hit_prio)
                for (int s = 0; s < NSRC; s++)
                    if (prio_idx == s) reg_rdata_o[PRIO_W-1:0] = prio_q[s];
            if (hit_pend)
                for (int s = 0; s < NSRC; s++)
                    if (pend_word == s / 32) reg_rdata_o[s % 32] = pend_vec[s];
            if (hit_en)
                for (int c = 0; c < NCTX; c++)
                    for (int s = 0; s < NSRC; s++)
                        if (en_ctx == c && en_word == s / 32) reg_rdata_o[s % 32] = en_q[c][s];
            if (hit_thr)
                for (int c = 0; c < NCTX; c++)
                    if (ctx_sel == c) reg_rdata_o[PRIO_W-1:0] = thr_q[c];
            if (hit_clm)
                reg_rdata_o[ID_W-1:0] = clm_id;
        end
    end

    p_claim_marks_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clm_fire && clm_id != '0) |=> busy_vec[$past(clm_id)]);

    p_complete_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_fire && cmp_ok && busy_vec[cmp_id]) |=> !busy_vec[$past(cmp_id)]);

endmodule

// File: tb/intc_core_tb.sv
module intc_core_tb;

    localparam int NSRC   = 40;
    localparam int NCTX   = 4;
    localparam int PRIO_W = 3;
    localparam int NW     = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic [NSRC-1:1]   irq_src;
    logic              req, we;
    logic [25:0]       addr;
    logic [31:0]       wdata;
    logic [31:0]       rdata;
    logic [NCTX-1:0]   irq;

    intc_core #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_irq_i(irq_src),
        .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ctx_irq_o(irq)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // ---------------- behavioural reference model ----------------
    // gateway state per source: 0 idle, 1 pending, 2 in flight
    int m_prio [NSRC];
    int m_st   [NSRC];
    bit m_en   [NCTX][NSRC];
    int m_thr  [NCTX];

    function automatic int m_best(int c);
        int bp = 0;
        int bi = 0;
        for (int s = 1; s < NSRC; s++)
            if (m_st[s] == 1 && m_en[c][s] && m_prio[s] > bp) begin
                bp = m_prio[s];
                bi = s;
            end
        return bi;
    endfunction

    function automatic bit m_irq(int c);
        return m_prio[m_best(c)] > m_thr[c];
    endfunction

    function automatic logic [31:0] m_read(int a);
        logic [31:0] r = '0;
        int off, c, w, s;
        if (a < 'h1000) begin
            s = a / 4;
            if (s < NSRC) r = 32'(m_prio[s]);
        end else if (a < 'h2000) begin
            w = (a - 'h1000) / 4;
            if (w < NW)
                for (int b = 0; b < 32; b++) begin
                    s = w * 32 + b;
                    if (s < NSRC && m_st[s] == 1) r[b] = 1'b1;
                end
        end else if (a < 'h200000) begin
            off = a - 'h2000;
            c = off / 128;
            w = (off % 128) / 4;
            if (c < NCTX && w < NW)
                for (int b = 0; b < 32; b++) begin
                    s = w * 32 + b;
                    if (s < NSRC && m_en[c][s]) r[b] = 1'b1;
                end
        end else begin
            off = a - 'h200000;
            c = off / 4096;
            if (c < NCTX && off % 4096 == 0) r = 32'(m_thr[c]);
            else if (c < NCTX && off % 4096 == 4) r = 32'(m_best(c));
        end
        return r;
    endfunction

    always @(posedge clk) begin : model
        int nst [NSRC];
        int a, off, c, w, s, id;
        if (!rst_n) begin
            for (int i = 0; i < NSRC; i++) begin
                m_prio[i] = 0;
                m_st[i] = 0;
            end
            for (int k = 0; k < NCTX; k++) begin
                m_thr[k] = 0;
                for (int i = 0; i < NSRC; i++) m_en[k][i] = 1'b0;
            end
        end else begin
            nst = m_st;
            a = int'(addr);
            if (req && a >= 'h200000) begin
                off = a - 'h200000;
                c = off / 4096;
                if (c < NCTX && off % 4096 == 4) begin
                    if (!we) begin
                        id = m_best(c);
                        if (id != 0) nst[id] = 2;
                    end else if (wdata != 0 && wdata < 32'(NSRC)) begin
                        id = int'(wdata);
                        if (m_st[id] == 2) nst[id] = 0;
                    end
                end
                if (we && c < NCTX && off % 4096 == 0) m_thr[c] = int'(wdata[PRIO_W-1:0]);
            end else if (req && we) begin
                if (a < 'h1000) begin
                    s = a / 4;
                    if (s > 0 && s < NSRC) m_prio[s] = int'(wdata[PRIO_W-1:0]);
                end else if (a < 'h2000) begin
                    w = (a - 'h1000) / 4;
                    if (w < NW)
                        for (int b = 0; b < 32; b++) begin
                            s = w * 32 + b;
                            if (s > 0 && s < NSRC && wdata[b] && m_st[s] == 0) nst[s] = 1;
                        end
                end else begin
                    off = a - 'h2000;
                    c = off / 128;
                    w = (off % 128) / 4;
                    if (c < NCTX && w < NW)
                        for (int b = 0; b < 32; b++) begin
                            s = w * 32 + b;
                            if (s > 0 && s < NSRC) m_en[c][s] = wdata[b];
                        end
                end
            end
            for (int i = 1; i < NSRC; i++)
                if (m_st[i] == 0 && irq_src[i]) nst[i] = 1;
            m_st = nst;
        end
    end

    // ---------------- per-cycle comparison ----------------
    task automatic tick(string tag);
        logic [31:0] exp;
        #1;
        for (int c = 0; c < NCTX; c++) begin
            total++;
            if (irq[c] !== m_irq(c)) begin
                bad++;
                $display("FAIL R7 ctx%0d irq actual=%b expected=%b", c, irq[c], m_irq(c));
            end
        end
        if (req && !we) begin
            exp = m_read(int'(addr));
            total++;
            if (rdata !== exp) begin
                bad++;
                $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr, rdata, exp);
            end
        end
        @(negedge clk);
    endtask

    task automatic wr(int a, logic [31:0] d, string tag);
        req = 1'b1; we = 1'b1; addr = 26'(a); wdata = d;
        tick(tag);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(int a, string tag);
        req = 1'b1; we = 1'b0; addr = 26'(a); wdata = '0;
        tick(tag);
        req = 1'b0;
    endtask

    function automatic string tag_of(int a);
        if (a < 'h1000) return "R2";
        if (a < 'h2000) return "R3";
        if (a < 'h200000) return "R5";
        if (a % 4096 == 4) return "R8";
        return "R6";
    endfunction

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        rst_n = 1'b0; irq_src = '0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd('h4, "R1"); rd('h1000, "R1"); rd('h2000, "R1");
        rd('h200000, "R1"); rd('h200004, "R1"); rd('h203004, "R1");

        // R2: priorities
        for (int s = 1; s < NSRC; s++) wr(4 * s, 32'(s % 8), "R2");
        wr('h14, 32'h6, "R2");          rd('h14, "R2");
        wr('h0, 32'h7, "R2");           rd('h0, "R2");
        wr(4 * 39, 32'hFFFF_FFFD, "R2"); rd(4 * 39, "R2");

        // R5: enables
        wr('h2000, 32'hFFFF_FFFF, "R5"); rd('h2000, "R5");
        wr('h2004, 32'h0000_00FF, "R5"); rd('h2004, "R5");
        wr('h2080, 32'h0000_0F0F, "R5"); rd('h2080, "R5");
        wr('h2184, 32'h0000_0010, "R5"); rd('h2184, "R5");

        // R6: thresholds
        wr('h200000, 32'h2, "R6"); wr('h201000, 32'h0, "R6");
        wr('h202000, 32'h6, "R6"); wr('h203000, 32'hFFFF_FFFF, "R6");
        rd('h200000, "R6"); rd('h203000, "R6");

        // R3: request line
        irq_src[9] = 1'b1; tick("R3");
        irq_src[9] = 1'b0; rd('h1000, "R3");

        // R4: software pending
        wr('h1004, 32'h0000_0009, "R4"); rd('h1004, "R4");
        wr('h1004, 32'h0000_0000, "R4"); rd('h1004, "R4");

        // R8: claim picks 35 (priority 3) over 9 (priority 1); 32 has priority 0
        rd('h200004, "R8");
        // R9: pending cleared, further raises ignored while in flight
        rd('h1004, "R9");
        wr('h1004, 32'h0000_0008, "R9"); rd('h1004, "R9");
        irq_src[35] = 1'b1; tick("R9"); rd('h1004, "R9");

        // R10: stray completion ignored, real completion re-arms
        wr('h200004, 32'd7, "R10"); rd('h1004, "R10");
        wr('h201004, 32'd35, "R10"); rd('h1004, "R10"); rd('h1004, "R10");
        irq_src[35] = 1'b0;
        rd('h200004, "R8"); wr('h200004, 32'd35, "R10");

        // R8: tie between 12 and 13 goes to 12
        wr(4 * 12, 32'h6, "R8"); wr(4 * 13, 32'h6, "R8");
        wr('h1000, 32'h0000_3000, "R8"); rd('h200004, "R8"); rd('h200004, "R8");

        // R11: unmapped
        rd('h1F00, "R11"); rd('h2200, "R11"); rd('h200008, "R11"); rd('h204000, "R11");
        wr('h1F00, 32'hFFFF_FFFF, "R11"); wr('h2200, 32'hFFFF_FFFF, "R11");
        wr('h200008, 32'h7, "R11"); wr('h204004, 32'd12, "R11");
        rd('h1000, "R11"); rd('h200000, "R11");

        // randomized mix
        for (int n = 0; n < 3000; n++) begin
            int kind, a;
            if ($urandom % 4 == 0) irq_src[1 + $urandom % (NSRC - 1)] ^= 1'b1;
            kind = int'($urandom % 6);
            case (kind)
                0: a = 4 * int'($urandom % NSRC);
                1: a = 'h1000 + 4 * int'($urandom % NW);
                2: a = 'h2000 + 'h80 * int'($urandom % NCTX) + 4 * int'($urandom % NW);
                3: a = 'h200000 + 'h1000 * int'($urandom % NCTX);
                default: a = 'h200004 + 'h1000 * int'($urandom % NCTX);
            endcase
            case ($urandom % 3)
                0: tick("R7");
                1: rd(a, tag_of(a));
                default: begin
                    if (kind >= 4) wr(a, 32'($urandom % (NSRC + 2)), "R10");
                    else wr(a, $urandom, tag_of(a));
                end
            endcase
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule